// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is a single timer channel that produces a pulse-width-modulated output. Software writes a period value and a compare value into two shadow (buffer) registers. The running channel works from a separate active count and active compare register. The active registers are refreshed from the buffers in only two cases: while a manual-update control bit is held, or when the counter expires with auto-reload enabled. Buffer writes therefore never disturb a period that is already under way.

The counter counts down by one on every clock in which an external tick enable is high and the channel is started. A period lasts one tick more than the value held in the count buffer. When the counter expires, the channel emits a one-clock expiry pulse. If auto-reload is set, the next period starts at once. If auto-reload is clear, the channel halts at zero, so clearing auto-reload is the way to shut the channel down at the end of the current period. The output pin compares the counter with the active compare value. A compare value of all ones (or any value at or above the period value) holds the output at a constant 100% duty.

The expected bring-up sequence has two steps. First, hold manual update with start clear. Then clear manual update and set start together with auto-reload.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the buffers, active count and active compare registers clear to zero and `expire` goes low. Directly after reset, with the invert bit clear, `pwm_out` is low.
- R2: The `ctrl` bit positions are: bit 0 start, bit 1 manual update, bit 2 invert, bit 3 auto-reload. In every clock where bit 1 is high, the active count and active compare registers take the buffer contents. Counting is suspended and no expiry pulse is produced.
- R3: With start high, manual update low and `tick_en` high, a nonzero counter drops by one per clock. A period lasts count-buffer + 1 ticks.
- R4: On a tick with the counter at zero and auto-reload high, both active registers are reloaded from the buffers. `expire` is high for exactly the following clock.
- R5: On a tick with the counter at zero and auto-reload low, the channel still pulses `expire` once. It then halts at zero: no further pulses, a constant output, and no restart from setting auto-reload alone. Only a manual update releases the halt.
- R6: With start low, or with `tick_en` low, the counter and `pwm_out` hold their values and no expiry pulse occurs.
- R7: A buffer write during a running period does not change that period. The new period length takes effect with the period that follows the next reload.
- R8: With invert high, `pwm_out` is high exactly when the active count is at or below the active compare value. With invert low, `pwm_out` is the complement. Over one period of N+1 ticks with compare C, the high time is min(C,N)+1 ticks when inverted, and the rest of the period otherwise.
- R9: An active compare value of all ones with invert high keeps `pwm_out` high for the whole period (100% duty).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick enable, one counter step per high clock |
| cnt_wr | input | 1 | Write strobe for the count buffer |
| cnt_wdata | input | CNT_W | Count buffer write data (ticks per period minus one) |
| cmp_wr | input | 1 | Write strobe for the compare buffer |
| cmp_wdata | input | CNT_W | Compare buffer write data |
| ctrl | input | 4 | Control bits: start, manual update, invert, auto-reload |
| pwm_out | output | 1 | PWM output level |
| expire | output | 1 | One-clock pulse at each counter expiry |

## Verification
The bench builds the channel with CNT_W = 8. At that width the all-ones compare code (255) can be written directly. The full-duty and compare-above-period cases can therefore be compared with ordinary duty settings inside short periods. A narrow counter also keeps every measured period to a few dozen clocks. This lets the bench time whole periods between expiry pulses, including the deferred effect of a buffer write and the halt after auto-reload is dropped.

// File: rtl/pwm_chan_pkg.sv
// Shared definitions for the double-buffered PWM channel.
// Assumes the control nibble arrives already decoded for this channel.
package pwm_chan_pkg;

    // Bit positions inside the per-channel control nibble.
    localparam int CTL_START  = 0;
    localparam int CTL_MANUAL = 1;
    localparam int CTL_INVERT = 2;
    localparam int CTL_RELOAD = 3;
    localparam int CTL_W      = 4;

    // Packed view of the control nibble, MSB first.
    typedef struct packed {
        logic reload;
        logic invert;
        logic manual;
        logic start;
    } chan_ctl_t;

endpackage

// File: rtl/pwm_buf_regs.sv
// Shadow registers for period and compare values.
// Software writes them at any time. They reach the counter only
// when the counter asks for a load. Reset clears both to zero.
module pwm_buf_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt_buf,
    output logic [CNT_W-1:0] cmp_buf
);

    // Capture the period buffer on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_buf <= '0;
        else if (cnt_wr)
            cnt_buf <= cnt_wdata;
    end

    // Capture the compare buffer on its write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_buf <= '0;
        else if (cmp_wr)
            cmp_buf <= cmp_wdata;
    end

endmodule

// File: rtl/pwm_down_counter.sv
// Active down-counter, active compare register and expiry logic.
// Manual update has priority over counting and clears a halt.
// The period ends on a tick taken at zero. The end either reloads
// (auto-reload set) or halts the channel until the next manual update.
// Assumes tick_en is a single-clock-wide enable from an external divider.
module pwm_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start,
    input  logic             manual,
    input  logic             reload,
    input  logic [CNT_W-1:0] cnt_buf,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cur_count,
    output logic [CNT_W-1:0] act_cmp,
    output logic             halted,
    output logic             expire
);

    logic run_tick;
    logic at_zero;
    logic period_end;

    // Decode the step condition and the end-of-period event.
    always_comb begin
        run_tick   = start && tick_en && !manual;
        at_zero    = (cur_count == '0);
        period_end = run_tick && at_zero && !halted;
    end

    // Update the counter, the compare register and the halt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_count <= '0;
            act_cmp   <= '0;
            halted    <= 1'b0;
        end else if (manual) begin
            cur_count <= cnt_buf;
            act_cmp   <= cmp_buf;
            halted    <= 1'b0;
        end else if (period_end) begin
            if (reload) begin
                cur_count <= cnt_buf;
                act_cmp   <= cmp_buf;
            end else begin
                halted    <= 1'b1;
            end
        end else if (run_tick && !at_zero) begin
            cur_count <= cur_count - 1'b1;
        end
    end

    // Register a one-clock pulse for every period end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            expire <= 1'b0;
        else
            expire <= period_end;
    end

endmodule

// File: rtl/pwm_level_gen.sv
// Output level stage: compares the counter with the active compare value
// and applies the polarity bit. Purely combinational from registers,
// so the pin follows the counter in the same clock.
module pwm_level_gen #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cur_count,
    input  logic [CNT_W-1:0] act_cmp,
    input  logic             invert,
    output logic             pwm_out
);

    logic in_active;

    // High phase while the counter has fallen to the compare value.
    always_comb begin
        in_active = (cur_count <= act_cmp);
        pwm_out   = invert ? in_active : !in_active;
    end

endmodule

// File: rtl/pwm_dbuf_channel.sv
// One double-buffered PWM timer channel.
// Joins the shadow registers, the active counter and the output stage.
// Assumes ctrl holds this channel's nibble from a shared control register.
module pwm_dbuf_channel #(
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_en,
    input  logic                          cnt_wr,
    input  logic [CNT_W-1:0]              cnt_wdata,
    input  logic                          cmp_wr,
    input  logic [CNT_W-1:0]              cmp_wdata,
    input  logic [pwm_chan_pkg::CTL_W-1:0] ctrl,
    output logic                          pwm_out,
    output logic                          expire
);

    import pwm_chan_pkg::*;

    chan_ctl_t        ctl;
    logic [CNT_W-1:0] cnt_buf_q;
    logic [CNT_W-1:0] cmp_buf_q;
    logic [CNT_W-1:0] cur_count;
    logic [CNT_W-1:0] act_cmp;
    logic             halted;

    // View the raw nibble as named control fields.
    always_comb ctl = chan_ctl_t'(ctrl);

    pwm_buf_regs #(.CNT_W(CNT_W)) u_bufs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .cnt_buf   (cnt_buf_q),
        .cmp_buf   (cmp_buf_q)
    );

    pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .start     (ctl.start),
        .manual    (ctl.manual),
        .reload    (ctl.reload),
        .cnt_buf   (cnt_buf_q),
        .cmp_buf   (cmp_buf_q),
        .cur_count (cur_count),
        .act_cmp   (act_cmp),
        .halted    (halted),
        .expire    (expire)
    );

    pwm_level_gen #(.CNT_W(CNT_W)) u_lvl (
        .cur_count (cur_count),
        .act_cmp   (act_cmp),
        .invert    (ctl.invert),
        .pwm_out   (pwm_out)
    );

endmodule

// File: rtl/pwm_dbuf_channel_chk.sv
// Property checker for the PWM channel, attached by bind.
// Observes ports and the internal buffer, counter and halt state.
module pwm_dbuf_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [3:0]       ctrl,
    input logic [CNT_W-1:0] cnt_buf,
    input logic [CNT_W-1:0] cmp_buf,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] act_cmp,
    input logic             halted,
    input logic             pwm_out,
    input logic             expire
);

    // R2
    manual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[1] |=> (count == $past(cnt_buf)) && (act_cmp == $past(cmp_buf)) && !expire);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && ctrl[0] && !ctrl[1] && count != '0) |=> (count == $past(count) - 1'b1));

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && ctrl[0] && !ctrl[1] && ctrl[3] && count == '0 && !halted)
        |=> (count == $past(cnt_buf)) && expire);

    // R5
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !ctrl[1]) |=> !expire && $stable(count));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick_en && ctrl[0]) && !ctrl[1]) |=> $stable(count) && !expire);

    // R9
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[2] && act_cmp == '1) |-> pwm_out);

endmodule

bind pwm_dbuf_channel pwm_dbuf_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .ctrl    (ctrl),
    .cnt_buf (cnt_buf_q),
    .cmp_buf (cmp_buf_q),
    .count   (cur_count),
    .act_cmp (act_cmp),
    .halted  (halted),
    .pwm_out (pwm_out),
    .expire  (expire)
);

// File: tb/pwm_dbuf_channel_test.sv
module pwm_dbuf_channel_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam logic [3:0] C_START = 4'b0001;
    localparam logic [3:0] C_MAN   = 4'b0010;
    localparam logic [3:0] C_INV   = 4'b0100;
    localparam logic [3:0] C_AR    = 4'b1000;

    // {invert, period value, compare value}
    localparam int NV = 9;
    localparam logic [16:0] VECS [0:NV-1] = '{
        {1'b1, 8'd9,  8'd3},
        {1'b0, 8'd9,  8'd3},
        {1'b1, 8'd4,  8'd0},
        {1'b1, 8'd7,  8'd7},
        {1'b1, 8'd7,  8'd200},
        {1'b1, 8'd15, 8'd255},
        {1'b0, 8'd15, 8'd255},
        {1'b1, 8'd0,  8'd0},
        {1'b1, 8'd20, 8'd10}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         cnt_wr = 1'b0;
    logic [W-1:0] cnt_wdata = '0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic [3:0]   ctrl = 4'b0000;
    logic         pwm_out;
    logic         expire;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dbuf_channel #(.CNT_W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .ctrl      (ctrl),
        .pwm_out   (pwm_out),
        .expire    (expire)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cnt_wr = 1'b0;
        cmp_wr = 1'b0;
        #1;
    endtask

    task automatic wr_bufs(input int n, input int c);
        cnt_wdata = W'(n);
        cmp_wdata = W'(c);
        cnt_wr = 1'b1;
        cmp_wr = 1'b1;
        step();
    endtask

    // Clocks from now until the next expiry pulse is seen.
    task automatic wait_expire(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!expire && n < 600);
    endtask

    // Run a number of clocks; report output stability and pulse count.
    task automatic quiet_run(input int cycles, output bit stable, output int pulses);
        logic lvl;
        lvl = pwm_out;
        stable = 1'b1;
        pulses = 0;
        for (int k = 0; k < cycles; k++) begin
            step();
            if (pwm_out !== lvl) stable = 1'b0;
            if (expire) pulses++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int pulses;
        bit stable;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(pwm_out == 1'b0, "R1 out after reset", int'(pwm_out), 0);
        check(expire == 1'b0, "R1 expire after reset", int'(expire), 0);
        tick_en = 1'b1;

        // R8 / R9 / R3 / R4: duty and period vectors
        for (int i = 0; i < NV; i++) begin
            int nv;
            int cv;
            int clip;
            int exp_hi;
            int highs;
            int exps;
            logic [3:0] iv;
            iv = VECS[i][16] ? C_INV : 4'b0000;
            nv = int'(VECS[i][15:8]);
            cv = int'(VECS[i][7:0]);
            clip = (cv >= nv) ? nv + 1 : cv + 1;
            exp_hi = VECS[i][16] ? clip : nv + 1 - clip;
            wr_bufs(nv, cv);
            ctrl = C_MAN | iv;
            step();
            ctrl = C_START | C_AR | iv;
            step();
            highs = 0;
            exps = 0;
            for (int k = 0; k <= nv; k++) begin
                if (pwm_out) highs++;
                if (expire) exps++;
                step();
            end
            check(highs == exp_hi, "R8/R9 high ticks per period", highs, exp_hi);
            check(exps == 1, "R4 one expiry per period", exps, 1);
        end

        // R3 / R7: period length and deferred buffer write
        ctrl = 4'b0000;
        wr_bufs(9, 0);
        ctrl = C_MAN | C_INV;
        step();
        ctrl = C_START | C_AR | C_INV;
        wait_expire(n);
        check(n == 10, "R3 period of buffer+1 ticks", n, 10);
        cnt_wdata = 8'd4;
        cnt_wr = 1'b1;
        wait_expire(n);
        check(n == 10, "R7 running period unchanged by write", n, 10);
        wait_expire(n);
        check(n == 5, "R7 new period after reload", n, 5);

        // R6: start clear holds, tick_en low holds
        ctrl = C_AR | C_INV;
        quiet_run(20, stable, pulses);
        check(stable, "R6 output held with start clear", int'(stable), 1);
        check(pulses == 0, "R6 no expiry with start clear", pulses, 0);
        ctrl = C_START | C_AR | C_INV;
        tick_en = 1'b0;
        quiet_run(10, stable, pulses);
        check(stable && pulses == 0, "R6 held with tick_en low", pulses, 0);
        tick_en = 1'b1;
        wait_expire(n);
        check(n == 5, "R6 resumes from held count", n, 5);

        // R5: auto-reload cleared finishes the period, then halts
        ctrl = C_START | C_INV;
        wait_expire(n);
        check(n == 5, "R5 current period runs to end", n, 5);
        quiet_run(30, stable, pulses);
        check(pulses == 0, "R5 no expiry after halt", pulses, 0);
        check(stable && pwm_out == 1'b1, "R5 output constant after halt", int'(pwm_out), 1);
        ctrl = C_START | C_AR | C_INV;
        quiet_run(10, stable, pulses);
        check(pulses == 0, "R5 auto-reload alone does not restart", pulses, 0);

        // R2: manual update held suspends counting
        wr_bufs(3, 1);
        ctrl = C_START | C_AR | C_MAN | C_INV;
        quiet_run(10, stable, pulses);
        check(pulses == 0, "R2 no expiry during manual update", pulses, 0);
        check(pwm_out == 1'b0, "R8 count 3 above compare 1 gives low", int'(pwm_out), 0);
        ctrl = C_START | C_AR | C_INV;
        wait_expire(n);
        check(n == 4, "R2 period from loaded buffer", n, 4);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule